// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block sits in front of a synchronous memory array and turns one supplied address into a burst of up to four beat addresses. Each clock cycle a load/advance control selects between two actions. With the control low the block takes a new command: the chip select, write request, order selection and full external address are captured, and that address becomes the first beat. With the control high the block steps its two-bit beat counter and produces the next beat address. On these step cycles the chip select and write request pins are not looked at, and the command captured at load stays in force.

The two low address bits follow one of two orders, fixed for the whole burst at the load cycle. In interleaved order each beat offset is the start offset XORed with the beat number. In linear order it is the start offset plus the beat number, wrapping modulo four. If stepping continues after the fourth beat, the sequence returns to the start offset and repeats. The upper address bits are taken from the load cycle and are never changed by the counter. Byte enables are registered on every cycle and belong only to the beat issued in that cycle.

All outputs are registered. The control pins are plain level signals with no handshake. The block accepts a new load or a step on every clock, and it exerts no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, cmd_valid, cmd_write, burst_active, cur_addr and beat_be are all zero.
- R2: A cycle with seq_adv=0 and chip_sel=1 presents ext_addr on cur_addr after that edge, sets cmd_valid to 1, sets cmd_write to wr_req, and sets burst_active to 0.
- R3: A cycle with seq_adv=0 and chip_sel=0 clears cmd_valid, cmd_write and burst_active. cur_addr then shows the start address of the last accepted load.
- R4: With order_sel=1 at load (interleaved), the low two bits of cur_addr on beat k (k=0 at load) are start XOR (k mod 4).
- R5: With order_sel=0 at load (linear), the low two bits of cur_addr on beat k are (start + k) mod 4.
- R6: cur_addr bits above bit 1 keep their load-cycle value on every step cycle.
- R7: On a step cycle (seq_adv=1), chip_sel and wr_req have no effect: cmd_valid and cmd_write keep their values.
- R8: After the fourth beat, further steps wrap, so the fifth beat's offset equals the start offset.
- R9: burst_active is 1 after a step of a valid command and 0 after any load cycle.
- R10: beat_be shows the byte_en value sampled at the most recent clock edge, on every cycle.
- R11: A step while cmd_valid=0 changes nothing: cmd_valid, burst_active and cur_addr stay as they were.
- R12: order_sel is sampled only on accepted loads; changing it during a burst does not alter the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_adv | input | 1 | 0 = load new command, 1 = step the burst |
| chip_sel | input | 1 | Command select, sampled on load cycles only |
| wr_req | input | 1 | 1 = write command, sampled on accepted loads only |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order, sampled on accepted loads |
| ext_addr | input | ADDR_W | Starting address |
| byte_en | input | BE_W | Byte enables for the beat issued in this cycle |
| cur_addr | output | ADDR_W | Address of the current beat |
| cmd_valid | output | 1 | A selected command is in force |
| cmd_write | output | 1 | The command in force is a write |
| burst_active | output | 1 | The current beat came from a step, not a load |
| beat_be | output | BE_W | Byte enables for the current beat |

## Verification
The bench runs every start offset in both orders, for reads and writes, through six beats. This exposes a linear sequence that fails to wrap, an interleave built as an adder, and a counter that stops or resets after the fourth beat instead of wrapping back to the start. During every step it toggles chip_sel, wr_req and order_sel, so a design that re-samples any of them would lose the command, flip its type or change order mid-burst. It also steps while deselected and varies the upper bits between loads. A design that lets the counter carry into the upper bits, or that starts counting without a valid command, would show a wrong address or a false burst_active.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [OFS_W-1:0] beat_ofs(
    input logic [OFS_W-1:0] base,
    input logic [OFS_W-1:0] k,
    input order_e           ord
  );
    logic [OFS_W-1:0] sum;
    sum = base + k;
    return (ord == ORD_INTERLEAVE) ? (base ^ k) : sum;
  endfunction
endpackage

// File: rtl/bseq_counter.sv
module bseq_counter
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [OFS_W-1:0] count,
  output logic             active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      active <= 1'b0;
    end else if (load) begin
      count  <= '0;
      active <= 1'b0;
    end else if (step) begin
      count  <= count + 1'b1;
      active <= 1'b1;
    end
  end

  // R8
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (count == OFS_W'($past(count) + 1'b1)));

  // R9
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!active && count == '0));
endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BE_W   = 4,
  localparam int UP_W  = ADDR_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             chip_sel,
  input  logic             wr_req,
  input  logic             order_in,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [BE_W-1:0]  byte_en,
  output logic             cmd_valid,
  output logic             cmd_write,
  output order_e           order_q,
  output logic [UP_W-1:0]  upper_q,
  output logic [OFS_W-1:0] base_q,
  output logic [BE_W-1:0]  beat_be
);
  logic accept;
  assign accept = load && chip_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
    end else if (load) begin
      cmd_valid <= chip_sel;
      cmd_write <= chip_sel && wr_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= ORD_LINEAR;
      upper_q <= '0;
      base_q  <= '0;
    end else if (accept) begin
      order_q <= order_e'(order_in);
      upper_q <= ext_addr[ADDR_W-1:OFS_W];
      base_q  <= ext_addr[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_be <= '0;
    else        beat_be <= byte_en;
  end

  // R7
  cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cmd_valid) && $stable(cmd_write)));

  // R12
  order_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(order_q));

  // R10
  be_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (beat_be == $past(byte_en)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BE_W   = 4,
  localparam int UP_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_adv,
  input  logic              chip_sel,
  input  logic              wr_req,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [BE_W-1:0]   byte_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic              burst_active,
  output logic [BE_W-1:0]   beat_be
);
  logic             load, step;
  logic [OFS_W-1:0] count, base_q, ofs;
  logic [UP_W-1:0]  upper_q;
  order_e           order_q;

  assign load = !seq_adv;
  assign step = seq_adv && cmd_valid;

  bseq_capture #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load), .chip_sel(chip_sel),
    .wr_req(wr_req), .order_in(order_sel), .ext_addr(ext_addr),
    .byte_en(byte_en), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .order_q(order_q), .upper_q(upper_q), .base_q(base_q), .beat_be(beat_be)
  );

  bseq_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .count(count), .active(burst_active)
  );

  assign ofs      = beat_ofs(base_q, count, order_q);
  assign cur_addr = {upper_q, ofs};

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_adv |=> (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W])));

  // R11
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_adv && !cmd_valid) |=> (!cmd_valid && !burst_active && $stable(cur_addr)));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_adv && chip_sel) |=> (cmd_valid && cur_addr == $past(ext_addr)));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 18;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_adv = 1'b0, chip_sel = 1'b0, wr_req = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [BW-1:0] byte_en = '0;
  logic [AW-1:0] cur_addr;
  logic cmd_valid, cmd_write, burst_active;
  logic [BW-1:0] beat_be;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .seq_adv(seq_adv), .chip_sel(chip_sel),
    .wr_req(wr_req), .order_sel(order_sel), .ext_addr(ext_addr),
    .byte_en(byte_en), .cur_addr(cur_addr), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .burst_active(burst_active), .beat_be(beat_be)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge.
  task automatic cyc(input logic adv, input logic cs, input logic wr, input logic ord,
                     input logic [AW-1:0] a, input logic [BW-1:0] be);
    seq_adv = adv; chip_sel = cs; wr_req = wr; order_sel = ord;
    ext_addr = a; byte_en = be;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] exp_ofs(input logic [1:0] s, input int k, input bit ilv);
    int kk;
    kk = k % 4;
    if (ilv) return s ^ 2'(kk);
    return 2'((int'(s) + kk) % 4);
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] start, last_start;
    logic [AW-3:0] up;
    logic [BW-1:0] be;
    int seed;
    seed = 3;
    last_start = '0;
    @(negedge clk);
    // R1
    check("R1 cur_addr", cur_addr, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 cmd_write", cmd_write, 0);
    check("R1 burst_active", burst_active, 0);
    check("R1 beat_be", beat_be, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          seed = seed * 37 + 11;
          up = (AW-2)'(seed);
          start = {up, 2'(s)};
          be = BW'(seed >> 3);
          cyc(1'b0, 1'b1, w[0], m[0], start, be);
          last_start = start;
          // R2
          check("R2 cur_addr", cur_addr, start);
          check("R2 cmd_valid", cmd_valid, 1);
          check("R2 cmd_write", cmd_write, w);
          check("R2 burst_active", burst_active, 0);
          check("R10 beat_be", beat_be, be);
          for (int k = 1; k < 6; k++) begin
            be = BW'(k * 5 + s);
            // R7 R12: chip_sel, wr_req, order_sel all flipped during steps
            cyc(1'b1, k[0], ~w[0], ~m[0], ~start, be);
            if (m == 1) check("R4 interleave ofs", cur_addr[1:0], exp_ofs(2'(s), k, 1'b1));
            else        check("R5 linear ofs", cur_addr[1:0], exp_ofs(2'(s), k, 1'b0));
            if (k >= 4) check("R8 wrap ofs", cur_addr[1:0], exp_ofs(2'(s), k, m[0]));
            check("R6 upper", cur_addr[AW-1:2], up);
            check("R7 cmd_valid", cmd_valid, 1);
            check("R7 cmd_write", cmd_write, w);
            check("R9 burst_active", burst_active, 1);
            check("R10 beat_be", beat_be, be);
          end
        end
      end
    end

    // R3: deselect load
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h15555, 4'h9);
    check("R3 cmd_valid", cmd_valid, 0);
    check("R3 cmd_write", cmd_write, 0);
    check("R3 burst_active", burst_active, 0);
    check("R3 cur_addr", cur_addr, last_start);
    // R11: step while idle
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h2aaaa, 4'h3);
      check("R11 cmd_valid", cmd_valid, 0);
      check("R11 burst_active", burst_active, 0);
      check("R11 cur_addr", cur_addr, last_start);
    end
    // R9: new load mid-burst clears burst_active and restarts
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 18'h00ff2, 4'h1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, '0, 4'h2);
    check("R9 active after step", burst_active, 1);
    check("R5 linear step", cur_addr, 18'h00ff3);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 18'h3fffd, 4'h4);
    check("R9 active after load", burst_active, 0);
    check("R2 reload addr", cur_addr, 18'h3fffd);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, '0, 4'h5);
    check("R4 interleave step", cur_addr, 18'h3fffc);
    check("R6 no carry", cur_addr[AW-1:2], 16'hffff);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule